// File: doc/BRIEF.md
# Dot-Clock Panel Timing Sequencer

This block produces the line and frame timing for an RGB parallel panel driven from a pixel clock. It counts clocks within a line and lines within a frame. From those two counts it derives the horizontal sync pulse, the vertical sync pulse, the data-enable strobe and an active-high pixel request that a fetch engine uses to pop pixels. Every timing value is given as a whole total measured from the start of the line or frame, and that total already includes the sync pulse. The sync pulse widths are given on their own. Each output has its own polarity select.

All timing inputs, the polarity selects and the launch-edge select are copied into a shadow set. The copy is taken on the last clock of a frame, and on every clock while sync generation is off, so a change made in the middle of a frame cannot tear the frame. A next-frame base address can be written at any time. It is promoted to the current base address, which can be read back, at the same frame boundary.

Sync generation and data transfer are started separately. The run status can only be set while sync generation is on. When the run request is withdrawn, the run status stays set until the downstream pixel FIFO reports empty, and only then clears. After that, sync generation may safely be switched off.

Top module: `dtg_timing_gen`

## Requirements
- R1: While rst_n is low at a clock edge, every output, including cur_base_o and running_o, is 0 after that edge.
- R2: When sync is on, a line lasts h_total_i clocks, numbered 0 to h_total_i-1. hsync_o is active for clocks 0 to h_sync_i-1 of each line and appears one clock after the count. The active level is high when hs_hi_i=1 and low when hs_hi_i=0.
- R3: With vs_in_clks_i=0, a frame lasts v_total_i lines and vsync_o is active during lines 0 to v_sync_i-1. Its level follows vs_hi_i in the same way that hsync_o follows hs_hi_i.
- R4: With vs_in_clks_i=1, vsync_o is active for the first v_sync_i clocks counted from clock 0 of line 0, even when that span crosses line ends.
- R5: pix_req_o is 1 exactly when the block is running, the clock count is at least h_wait_i and below h_wait_i+h_active_i, and the line count is at least v_wait_i and below v_wait_i+v_active_i. de_o carries the same window, high-active when de_hi_i=1.
- R6: The timing, polarity and edge inputs are sampled only on the last clock of a frame, or on any clock while sync_en_i=0. A change made mid-frame has no effect on the outputs until the next frame.
- R7: nb_wr_i=1 stores nb_addr_i as the next base. cur_base_o takes the stored next base on the last clock of a frame, or on any clock while sync_en_i=0, and otherwise holds.
- R8: running_o sets only when run_req_i=1 and sync_en_i=1 are seen at the same edge. A run request made while sync is off is ignored.
- R9: running_o stays 1 while run_req_i=1. After run_req_i drops, running_o clears at the first edge where fifo_empty_i=1.
- R10: While sync_en_i=0 the counters are held at zero, hsync_o, vsync_o and de_o sit at their inactive levels, and pix_req_o is 0. Turning sync on starts a frame at line 0, clock 0.
- R11: pclk_fall_o presents the shadowed launch-on-falling-edge select, with 1 meaning falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_en_i | input | 1 | Sync generation on |
| run_req_i | input | 1 | Request to start or keep data transfer |
| fifo_empty_i | input | 1 | Downstream pixel FIFO is empty |
| h_total_i | input | 18 | Clocks per line, all phases included (at least 1) |
| h_sync_i | input | 18 | Horizontal sync width in clocks |
| h_wait_i | input | 12 | Clocks from line start to first valid pixel |
| h_active_i | input | 16 | Valid pixels per line |
| v_total_i | input | 18 | Lines per frame, all phases included (at least 1) |
| v_sync_i | input | 18 | Vertical sync width in lines or clocks |
| v_wait_i | input | 16 | Lines from frame start to first active line |
| v_active_i | input | 16 | Active lines per frame |
| vs_in_clks_i | input | 1 | Vertical sync width counted in clocks when 1 |
| hs_hi_i | input | 1 | hsync active-high select |
| vs_hi_i | input | 1 | vsync active-high select |
| de_hi_i | input | 1 | data-enable active-high select |
| fall_edge_i | input | 1 | Launch data on the falling pixel-clock edge |
| nb_wr_i | input | 1 | Write strobe for the next base address |
| nb_addr_i | input | 32 | Next frame-buffer base address |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_req_o | output | 1 | Active-high pixel request |
| pclk_fall_o | output | 1 | Shadowed launch-edge select |
| running_o | output | 1 | Run status |
| cur_base_o | output | 32 | Current frame-buffer base address |

## Verification
A clock counter that drifts shows on hsync_o within one line. A wrong line count shows on vsync_o or on the data-enable window within one frame. A shadow set that reloads at the wrong moment changes a pulse width or the position of the window in the frame after a mid-frame change, instead of waiting for the frame end. A base-address swap on the wrong cycle appears on cur_base_o on that same cycle. A run-status error appears one clock after the run request or the FIFO-empty input changes.

// File: rtl/dtg_pkg.sv
// Package: field widths and the shadowed timing configuration type.
// Assumes: all totals are at least 1; wait and active sums fit in the totals.
package dtg_pkg;
    localparam int CNT_W   = 18;  // period, pulse-width and counter width
    localparam int HWAIT_W = 12;  // horizontal wait field width
    localparam int VWAIT_W = 16;  // vertical wait field width
    localparam int ACT_W   = 16;  // active width and height fields

    typedef struct packed {
        logic [CNT_W-1:0]   h_total;
        logic [CNT_W-1:0]   h_sync;
        logic [HWAIT_W-1:0] h_wait;
        logic [ACT_W-1:0]   h_act;
        logic [CNT_W-1:0]   v_total;
        logic [CNT_W-1:0]   v_sync;
        logic [VWAIT_W-1:0] v_wait;
        logic [ACT_W-1:0]   v_act;
        logic               vs_in_clks;
        logic               hs_hi;
        logic               vs_hi;
        logic               de_hi;
        logic               fall_edge;
    } dtg_cfg_t;
endpackage

// File: rtl/dtg_shadow.sv
// Shadow store: holds the frame-stable copy of the timing configuration
// and the current/next base address pair.
// Assumes: frame_end is a one-clock strobe on the last clock of a frame.
module dtg_shadow
    import dtg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic              frame_end,
    input  dtg_cfg_t          cfg_live,
    input  logic              nb_wr,
    input  logic [ADDR_W-1:0] nb_addr,
    output dtg_cfg_t          cfg_sh,
    output logic [ADDR_W-1:0] cur_base
);
    logic [ADDR_W-1:0] next_base;
    logic              load;

    // Reload point: any clock while idle, otherwise the frame boundary.
    assign load = !sync_en || frame_end;

    // Capture the next base address on each write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     next_base <= '0;
        else if (nb_wr) next_base <= nb_addr;
    end

    // Copy configuration and promote the base address at the reload point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_sh   <= '0;
            cur_base <= '0;
        end else if (load) begin
            cfg_sh   <= cfg_live;
            cur_base <= next_base;
        end
    end
endmodule

// File: rtl/dtg_counters.sv
// Line/frame counters: clock-in-line, line-in-frame, and clocks since frame
// start (saturating). All held at zero while sync generation is off.
// Assumes: h_total and v_total are at least 1 and only change at frame_end.
module dtg_counters
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_en,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] v_total,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic [CNT_W-1:0] f_clk,
    output logic             frame_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic line_end;
    logic last_line;

    // Terminal-count decode for the line and the frame.
    always_comb begin
        line_end  = (h_cnt == h_total - ONE);
        last_line = (v_cnt == v_total - ONE);
        frame_end = sync_en && line_end && last_line;
    end

    // Advance the clock and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_en) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= last_line ? '0 : v_cnt + ONE;
        end else begin
            h_cnt <= h_cnt + ONE;
        end
    end

    // Count clocks since frame start, saturating at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_en || frame_end) f_clk <= '0;
        else if (f_clk != '1)                f_clk <= f_clk + ONE;
    end
endmodule

// File: rtl/dtg_run.sv
// Run handshake: run status sets only with sync on, and on stop it waits
// for the downstream FIFO to drain before clearing.
// Assumes: fifo_empty comes from the same clock domain.
module dtg_run (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic run_req,
    input  logic fifo_empty,
    output logic running
);
    // Set on request with sync on; clear after request drop and drain.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  running <= 1'b0;
        else if (!running && run_req && sync_en)     running <= 1'b1;
        else if (running && !run_req && fifo_empty)  running <= 1'b0;
    end
endmodule

// File: rtl/dtg_timing_gen.sv
// Top: panel timing sequencer. Decodes the sync pulses and the active
// window from the counters against the shadowed configuration, applies
// the polarities and registers every output.
// Assumes: a single pixel-clock domain; wait+active fits inside each total.
module dtg_timing_gen
    import dtg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_en_i,
    input  logic               run_req_i,
    input  logic               fifo_empty_i,
    input  logic [CNT_W-1:0]   h_total_i,
    input  logic [CNT_W-1:0]   h_sync_i,
    input  logic [HWAIT_W-1:0] h_wait_i,
    input  logic [ACT_W-1:0]   h_active_i,
    input  logic [CNT_W-1:0]   v_total_i,
    input  logic [CNT_W-1:0]   v_sync_i,
    input  logic [VWAIT_W-1:0] v_wait_i,
    input  logic [ACT_W-1:0]   v_active_i,
    input  logic               vs_in_clks_i,
    input  logic               hs_hi_i,
    input  logic               vs_hi_i,
    input  logic               de_hi_i,
    input  logic               fall_edge_i,
    input  logic               nb_wr_i,
    input  logic [ADDR_W-1:0]  nb_addr_i,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic               pix_req_o,
    output logic               pclk_fall_o,
    output logic               running_o,
    output logic [ADDR_W-1:0]  cur_base_o
);
    localparam int WW = CNT_W + 1;  // window bound width, room for the sum

    dtg_cfg_t         cfg_live, sh;
    logic [CNT_W-1:0] h_cnt, v_cnt, f_clk;
    logic             frame_end;
    logic [WW-1:0]    h_lo, h_hi, v_lo, v_hi;
    logic             hs_act, vs_act, win;

    // Gather the live configuration inputs into one record.
    always_comb begin
        cfg_live.h_total    = h_total_i;
        cfg_live.h_sync     = h_sync_i;
        cfg_live.h_wait     = h_wait_i;
        cfg_live.h_act      = h_active_i;
        cfg_live.v_total    = v_total_i;
        cfg_live.v_sync     = v_sync_i;
        cfg_live.v_wait     = v_wait_i;
        cfg_live.v_act      = v_active_i;
        cfg_live.vs_in_clks = vs_in_clks_i;
        cfg_live.hs_hi      = hs_hi_i;
        cfg_live.vs_hi      = vs_hi_i;
        cfg_live.de_hi      = de_hi_i;
        cfg_live.fall_edge  = fall_edge_i;
    end

    dtg_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_en   (sync_en_i),
        .frame_end (frame_end),
        .cfg_live  (cfg_live),
        .nb_wr     (nb_wr_i),
        .nb_addr   (nb_addr_i),
        .cfg_sh    (sh),
        .cur_base  (cur_base_o)
    );

    dtg_counters u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_en   (sync_en_i),
        .h_total   (sh.h_total),
        .v_total   (sh.v_total),
        .h_cnt     (h_cnt),
        .v_cnt     (v_cnt),
        .f_clk     (f_clk),
        .frame_end (frame_end)
    );

    dtg_run u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_en    (sync_en_i),
        .run_req    (run_req_i),
        .fifo_empty (fifo_empty_i),
        .running    (running_o)
    );

    // Decode sync pulses and the active window from the counters.
    always_comb begin
        h_lo   = WW'(sh.h_wait);
        h_hi   = h_lo + WW'(sh.h_act);
        v_lo   = WW'(sh.v_wait);
        v_hi   = v_lo + WW'(sh.v_act);
        hs_act = sync_en_i && (h_cnt < sh.h_sync);
        vs_act = sync_en_i && (sh.vs_in_clks ? (f_clk < sh.v_sync)
                                             : (v_cnt < sh.v_sync));
        win    = sync_en_i && running_o
              && (WW'(h_cnt) >= h_lo) && (WW'(h_cnt) < h_hi)
              && (WW'(v_cnt) >= v_lo) && (WW'(v_cnt) < v_hi);
    end

    // Register the panel outputs with their polarities applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o     <= 1'b0;
            vsync_o     <= 1'b0;
            de_o        <= 1'b0;
            pix_req_o   <= 1'b0;
            pclk_fall_o <= 1'b0;
        end else begin
            hsync_o     <= hs_act ~^ sh.hs_hi;
            vsync_o     <= vs_act ~^ sh.vs_hi;
            de_o        <= win ~^ sh.de_hi;
            pix_req_o   <= win;
            pclk_fall_o <= sh.fall_edge;
        end
    end
endmodule

// File: rtl/dtg_checker.sv
// Checker: temporal properties of the run handshake, the pixel request
// gating and the base-address swap point. Bound into dtg_timing_gen.
module dtg_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_en_i,
    input logic              run_req_i,
    input logic              fifo_empty_i,
    input logic              running_o,
    input logic              pix_req_o,
    input logic              frame_end,
    input logic [ADDR_W-1:0] cur_base_o
);
    // R8
    run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> ($past(sync_en_i) && $past(run_req_i)));

    // R9
    run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> ($past(fifo_empty_i) && !$past(run_req_i)));

    // R9
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && run_req_i) |=> running_o);

    // R5
    pix_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req_o |-> ($past(running_o) && $past(sync_en_i)));

    // R7
    base_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_base_o) |-> ($past(frame_end) || !$past(sync_en_i)));
endmodule

bind dtg_timing_gen dtg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_en_i    (sync_en_i),
    .run_req_i    (run_req_i),
    .fifo_empty_i (fifo_empty_i),
    .running_o    (running_o),
    .pix_req_o    (pix_req_o),
    .frame_end    (frame_end),
    .cur_base_o   (cur_base_o)
);

// File: tb/dtg_timing_gen_test.sv
module dtg_timing_gen_test;
    import dtg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_en = 1'b0, run_req = 1'b0, fifo_empty = 1'b1;
    logic        nb_wr = 1'b0;
    logic [31:0] nb_addr = '0;
    dtg_cfg_t    cfg = '0;
    logic        hsync, vsync, de, pix_req, pclk_fall, running;
    logic [31:0] cur_base;

    int n_chk = 0, n_bad = 0;
    bit chk_on = 1'b0;

    always #5 clk = ~clk;

    dtg_timing_gen #(.ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .sync_en_i(sync_en), .run_req_i(run_req),
        .fifo_empty_i(fifo_empty),
        .h_total_i(cfg.h_total), .h_sync_i(cfg.h_sync), .h_wait_i(cfg.h_wait),
        .h_active_i(cfg.h_act), .v_total_i(cfg.v_total), .v_sync_i(cfg.v_sync),
        .v_wait_i(cfg.v_wait), .v_active_i(cfg.v_act),
        .vs_in_clks_i(cfg.vs_in_clks), .hs_hi_i(cfg.hs_hi), .vs_hi_i(cfg.vs_hi),
        .de_hi_i(cfg.de_hi), .fall_edge_i(cfg.fall_edge),
        .nb_wr_i(nb_wr), .nb_addr_i(nb_addr),
        .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_req_o(pix_req),
        .pclk_fall_o(pclk_fall), .running_o(running), .cur_base_o(cur_base)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit in_win(input int x, input int lo, input int len);
        return (x >= lo) && (x < lo + len);
    endfunction

    function automatic bit pol(input bit act, input bit hi);
        return act == hi;
    endfunction

    // Reference model of the requirements, advanced on each rising edge.
    dtg_cfg_t m_sh;
    int  m_h, m_v, m_f;
    bit  m_run, m_sync_prev, m_tear, m_vs_clk;
    logic [31:0] m_next, m_cur;
    bit  e_hs, e_vs, e_de, e_pr, e_pf;
    bit  fe, le, win, hs_a, vs_a;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sh = '0; m_h = 0; m_v = 0; m_f = 0; m_run = 0;
            m_next = '0; m_cur = '0; m_sync_prev = 0; m_tear = 0; m_vs_clk = 0;
            e_hs = 0; e_vs = 0; e_de = 0; e_pr = 0; e_pf = 0;
        end else begin
            le   = (m_h == int'(m_sh.h_total) - 1);
            fe   = sync_en && le && (m_v == int'(m_sh.v_total) - 1);
            hs_a = sync_en && (m_h < int'(m_sh.h_sync));
            vs_a = sync_en && (m_sh.vs_in_clks ? (m_f < int'(m_sh.v_sync))
                                               : (m_v < int'(m_sh.v_sync)));
            win  = sync_en && m_run
                && in_win(m_h, int'(m_sh.h_wait), int'(m_sh.h_act))
                && in_win(m_v, int'(m_sh.v_wait), int'(m_sh.v_act));
            e_hs = pol(hs_a, m_sh.hs_hi);
            e_vs = pol(vs_a, m_sh.vs_hi);
            e_de = pol(win, m_sh.de_hi);
            e_pr = win;
            e_pf = m_sh.fall_edge;
            m_sync_prev = sync_en;
            m_tear = (m_sh != cfg);
            m_vs_clk = m_sh.vs_in_clks;
            if (!m_run && run_req && sync_en)         m_run = 1;
            else if (m_run && !run_req && fifo_empty) m_run = 0;
            if (!sync_en || fe) begin m_sh = cfg; m_cur = m_next; end
            if (nb_wr) m_next = nb_addr;
            if (!sync_en) begin m_h = 0; m_v = 0; end
            else if (le) begin
                m_h = 0;
                m_v = (m_v == int'(m_sh.v_total) - 1 && fe) ? 0 : m_v + 1;
                if (fe) m_v = 0;
            end else m_h = m_h + 1;
            if (!sync_en || fe) m_f = 0;
            else if (m_f < 262143) m_f = m_f + 1;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            string t;
            t = !m_sync_prev ? "R10" : (m_tear ? "R6" : "R2");
            chk(hsync == e_hs, t, "hsync", hsync, e_hs);
            t = !m_sync_prev ? "R10" : (m_tear ? "R6" : (m_vs_clk ? "R4" : "R3"));
            chk(vsync == e_vs, t, "vsync", vsync, e_vs);
            t = !m_sync_prev ? "R10" : "R5";
            chk(de == e_de, t, "de", de, e_de);
            chk(pix_req == e_pr, t, "pix_req", pix_req, e_pr);
            chk(pclk_fall == e_pf, "R11", "pclk_fall", pclk_fall, e_pf);
            chk(cur_base == m_cur, "R7", "cur_base", cur_base, m_cur);
            t = m_run ? "R8" : "R9";
            chk(running == m_run, t, "running", running, m_run);
        end
    end

    task automatic pick_cfg(output dtg_cfg_t n);
        int hs, hb, ha, hf, vs, vb, va, vf;
        hs = 1 + $urandom % 3; hb = $urandom % 3; ha = 1 + $urandom % 6; hf = $urandom % 3;
        vs = 1 + $urandom % 2; vb = $urandom % 2; va = 1 + $urandom % 4; vf = $urandom % 2;
        n.h_sync  = CNT_W'(hs);
        n.h_wait  = HWAIT_W'(hs + hb);
        n.h_act   = ACT_W'(ha);
        n.h_total = CNT_W'(hs + hb + ha + hf);
        n.v_wait  = VWAIT_W'(vs + vb);
        n.v_act   = ACT_W'(va);
        n.v_total = CNT_W'(vs + vb + va + vf);
        n.vs_in_clks = 1'($urandom % 2);
        n.v_sync  = n.vs_in_clks ? CNT_W'(1 + $urandom % (2 * (hs + hb + ha + hf)))
                                 : CNT_W'(vs);
        n.hs_hi = 1'($urandom % 2); n.vs_hi = 1'($urandom % 2);
        n.de_hi = 1'($urandom % 2); n.fall_edge = 1'($urandom % 2);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            nb_wr = ($urandom % 32) == 0;
            nb_addr = $urandom;
            fifo_empty = ($urandom % 2) == 0;
            if (($urandom % 64) == 0) run_req = ~run_req;
        end
    endtask

    initial begin
        dtg_cfg_t c;
        void'($urandom(32'd20240611));
        pick_cfg(c); cfg = c;
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        chk(hsync == 0 && vsync == 0 && de == 0 && pix_req == 0, "R1", "sync outputs",
            {hsync, vsync, de, pix_req}, 0);
        chk(running == 0, "R1", "running", running, 0);
        chk(cur_base == 0 && pclk_fall == 0, "R1", "cur_base", cur_base, 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R8: run request ignored with sync off
        run_req = 1'b1;
        repeat (10) @(negedge clk);
        chk(running == 0, "R8", "running without sync", running, 0);
        run_req = 1'b0;
        for (int k = 0; k < 16; k++) begin
            pick_cfg(c);
            if (k % 2 == 0) begin
                sync_en = 1'b0;            // R10: quiet restart
                repeat (3) @(negedge clk);
                cfg = c;
                sync_en = 1'b1;
            end else begin
                cfg = c;                   // R6: mid-frame change
            end
            run_cycles(700);
        end
        // R9: drain handshake
        @(negedge clk); fifo_empty = 1'b0; run_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(running == 1, "R8", "running after request", running, 1);
        run_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(running == 1, "R9", "running while FIFO busy", running, 1);
        fifo_empty = 1'b1;
        @(negedge clk);
        chk(running == 0, "R9", "running after drain", running, 0);
        // R10: sync off gives inactive levels
        sync_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(pix_req == 0 && hsync == !cfg.hs_hi, "R10", "idle hsync", hsync, !cfg.hs_hi);
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule